// File: doc/BRIEF.md
# Push-Button Debounce and Press Pulse

This block turns one raw, asynchronous push-button signal into two outputs. One is a clean debounced level. The other is a pulse exactly one clock wide for each accepted press. The raw input first goes through a two-stage synchroniser. A hold counter then runs while the synchronised input differs from the stored stable level. The stable level takes the new value only after the input has stayed constant for a parameterised number of cycles. The default is 1,000,000 cycles, which is 10 ms at 100 MHz and longer than typical contact bounce.

An edge detector compares the stable level with its registered copy from the previous cycle. It raises the press pulse only on a low-to-high change. The pulse can therefore drive a count or step enable in downstream logic directly.

Top module: `btn_press_pulse`

## Requirements
- R1: While rst_ni is low, level_o and press_o are 0. After reset the stable level starts at 0 even if the button is already held.
- R2: The raw input reaches the filter only through two flip-flops in series. An input change therefore cannot affect level_o sooner than HOLD_CYCLES+2 cycles after it is sampled.
- R3: level_o changes to the synchronised input value only after that value has differed from level_o on HOLD_CYCLES consecutive clock edges.
- R4: Any return of the synchronised input to the current level_o value restarts the hold count. A pulse or bounce shorter than HOLD_CYCLES leaves level_o unchanged.
- R5: press_o is 1 for exactly one cycle, the first cycle in which level_o is 1 after being 0 in the cycle before. It is never high for two consecutive cycles.
- R6: A release (level_o falling from 1 to 0) never produces a press_o pulse.
- R7: level_o changes only when the held input has reached the hold limit. It never toggles on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| btn_i | input | 1 | Raw button, asynchronous, active high |
| level_o | output | 1 | Debounced button level |
| press_o | output | 1 | One-cycle pulse per accepted press |

## Verification
The bench builds the block with HOLD_CYCLES set to 16 instead of one million. With that value, bounce bursts, a glitch one cycle shorter than the limit, an input held exactly at the limit, and a release can all run within a few hundred cycles. The exact acceptance cycle counted through the synchroniser can also be checked. Because the hold limit is only a counter compare, the short setting exercises the same logic as the default.

// File: rtl/btn_pkg.sv
package btn_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_filter.sv
module btn_filter
  import btn_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o
);
  localparam int unsigned CW = cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (d_i == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LIMIT) begin
      cnt_q   <= '0;
      level_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/btn_rise.sv
module btn_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign pulse_o = level_i & ~prev_q;
endmodule

// File: rtl/btn_press_pulse.sv
module btn_press_pulse #(
  parameter int unsigned HOLD_CYCLES = 1000000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic level_o,
  output logic press_o
);
  logic btn_s;
  logic level_s;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_i), .q_o(btn_s)
  );

  btn_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_s), .level_o(level_s)
  );

  btn_rise u_rise (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_s), .pulse_o(press_o)
  );

  assign level_o = level_s;
endmodule

// File: rtl/btn_press_pulse_chk.sv
module btn_press_pulse_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic btn_i,
  input logic level_o,
  input logic press_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o); // R5
  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |-> level_o); // R5
  AST_NO_RELEASE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_o |-> !press_o); // R6
  AST_NO_FAST_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(level_o) |=> $stable(level_o)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!level_o && !press_o)); // R1
endmodule

bind btn_press_pulse btn_press_pulse_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .btn_i(btn_i),
  .level_o(level_o), .press_o(press_o)
);

// File: tb/tb_btn_press_pulse.sv
module tb_btn_press_pulse;
  localparam int unsigned HOLD = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic btn = 1'b0;
  logic level, press;
  int   n_chk = 0;
  int   n_bad = 0;
  int   n_press = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  btn_press_pulse #(.HOLD_CYCLES(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_i(btn), .level_o(level), .press_o(press)
  );

  always @(negedge clk) if (rst_ni && press) n_press++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    btn = 1'b1;
    rst_ni = 1'b0;
    step(3);
    check("R1 level in reset", level, 0);
    check("R1 press in reset", press, 0);
    @(negedge clk) rst_ni = 1'b1;
    step(1);
    check("R1 level after reset", level, 0);
    check("R1 press after reset", press, 0);
    // held button is accepted later but starts from 0
    step(HOLD + 4);
    check("R1 held accepted", level, 1);
    check("R1 held yields one pulse", n_press, 1);
    btn = 1'b0;
    step(HOLD + 6);
    n_press = 0;
  endtask

  // input changed at a negedge; sync takes 2 edges, then HOLD edges of count
  task automatic t_latency();
    btn = 1'b1;
    step(HOLD + 1);
    check("R2 not yet accepted", level, 0);
    step(1);
    check("R3 accepted at limit", level, 1);
    check("R5 pulse cycle", press, 1);
    step(1);
    check("R5 pulse ended", press, 0);
    check("R5 one pulse", n_press, 1);
    btn = 1'b0;
    step(HOLD + 1);
    check("R3 release not yet", level, 1);
    step(1);
    check("R3 release accepted", level, 0);
    check("R6 no release pulse", n_press, 1);
    step(4);
    n_press = 0;
  endtask

  task automatic t_short();
    btn = 1'b1;
    step(HOLD - 1);
    btn = 1'b0;
    step(HOLD + 6);
    check("R4 short press level", level, 0);
    check("R4 short press no pulse", n_press, 0);
  endtask

  task automatic t_bounce();
    for (int i = 0; i < 6; i++) begin
      btn = 1'b1; step(3 + i);
      btn = 1'b0; step(2);
    end
    check("R4 bounce level", level, 0);
    check("R4 bounce no pulse", n_press, 0);
    btn = 1'b1;
    step(HOLD + 4);
    check("R4 after bounce level", level, 1);
    check("R5 bounce then one pulse", n_press, 1);
    for (int i = 0; i < 4; i++) begin
      btn = 1'b0; step(4);
      btn = 1'b1; step(2);
    end
    btn = 1'b0;
    step(HOLD + 4);
    check("R6 release bounce level", level, 0);
    check("R6 release bounce no pulse", n_press, 1);
    n_press = 0;
  endtask

  task automatic t_repeat();
    for (int i = 0; i < 3; i++) begin
      btn = 1'b1; step(HOLD + 5);
      btn = 1'b0; step(HOLD + 5);
    end
    check("R5 three presses three pulses", n_press, 3);
  endtask

  initial begin
    step(1);
    t_reset();
    t_latency();
    t_short();
    t_bounce();
    t_repeat();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule